// File: doc/BRIEF.md
# Value-holding reorder buffer

This block is a circular reorder buffer that also holds the results of instructions still in flight. It replaces both a separate physical register file and a free list. At dispatch the next sequential slot is claimed, and the index of that slot becomes the renamed destination tag of the instruction. Each slot stores the architectural destination number, a finished flag and the result value. A functional unit writes its result back into the slot named by its tag. Dependent instructions can read a finished value by tag.

The oldest slot retires only once it has finished. On retirement, its destination number and value drive a write port into the architectural register file, and the slot becomes free in that same cycle. A slot is not freed when a later instruction targets the same register. A flush clears the buffer completely.

Occupancy is tracked by a three-state machine:

| State | Meaning |
|---|---|
| OCC_EMPTY | No slot is held |
| OCC_PART | Some slots are held |
| OCC_FULL | Every slot is held |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| T_FILL | OCC_EMPTY | OCC_PART | First allocation |
| T_TOPUP | OCC_PART | OCC_FULL | An allocation without a retirement claims the last free slot |
| T_DRAIN | OCC_PART | OCC_EMPTY | A retirement without an allocation frees the last held slot |
| T_RELEASE | OCC_FULL | OCC_PART | Any retirement |
| T_FLUSH | any state | OCC_EMPTY | Flush |

Top module: `vrob_top`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `cm_en` is 0, `alloc_tag` is 0 and `rd_done` is 0 for every tag.
- R2: Accepted allocations receive consecutive tags starting from 0. `alloc_tag` shows the tag that the next accepted allocation will get, and it changes only on an accepted allocation or a flush.
- R3: After DEPTH accepted allocations with no retirement, `full` is 1. While `full` is 1, `alloc_ok` stays 0 and the tail does not move.
- R4: A writeback to a held slot sets the slot's finished flag and stores `wb_data`. From the next cycle on, reading that tag gives `rd_done`=1 and `rd_data` equal to the value written.
- R5: `cm_en` is 1 only when the oldest held slot has finished. It then presents that slot's destination on `cm_areg` and its value on `cm_data`. A finished younger slot never retires ahead of an unfinished older one.
- R6: A retirement frees its slot at that clock edge. From the next cycle, reading the freed tag gives `rd_done`=0, and the buffer is no longer full.
- R7: A writeback to a slot that is not held is ignored. The slot still reads `rd_done`=0 after it is later allocated.
- R8: A flush empties the buffer, clears every finished flag, resets both pointers to 0 and suppresses `cm_en` in its own cycle.
- R9: `empty` and `full` are never both 1. An allocation and a retirement in the same cycle leave the occupancy unchanged.
- R10: Tags wrap from DEPTH-1 back to 0, and a reused slot starts out unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clears the whole buffer |
| alloc_req | input | 1 | Dispatch asks for a slot |
| alloc_areg | input | AREG_W | Architectural destination of the dispatching instruction |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_tag | output | IDX_W | Tag given to the allocation |
| full | output | 1 | Every slot held |
| empty | output | 1 | No slot held |
| wb_en | input | 1 | Writeback strobe |
| wb_tag | input | IDX_W | Slot being written back |
| wb_data | input | DATA_W | Result value |
| rd_tag | input | IDX_W | Slot being read by an operand lookup |
| rd_done | output | 1 | Looked-up slot is held and finished |
| rd_data | output | DATA_W | Value of the looked-up slot |
| cm_en | output | 1 | Write enable to the architectural register file |
| cm_areg | output | AREG_W | Architectural register being written |
| cm_data | output | DATA_W | Value being written |

## Verification
The assertions assume that flush and reset are the only ways the pointers can jump. They also assume that the tag outputs are compared with DEPTH-1 before they wrap. Neither assumption depends on the writeback traffic.

The stimulus freely writes back to slots that are not held, to slots that have already finished, and to the slot that is retiring. It does this so that the ignore rules are exercised. It never relies on an order between inputs inside one cycle.

A long arithmetic sweep covers every combination that it reaches. In that sweep, allocate, writeback and lookup tags step with different strides, and a flush lands midway through.

// File: rtl/vrob_pkg.sv
package vrob_pkg;

    // Occupancy class of the buffer
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

endpackage

// File: rtl/vrob_ctrl.sv
module vrob_ctrl
    import vrob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             alloc_req,
    input  logic             head_done,
    output logic             alloc_ok,
    output logic             commit_ok,
    output logic [IDX_W-1:0] head_q,
    output logic [IDX_W-1:0] tail_q,
    output logic             full,
    output logic             empty
);

    localparam int CNT_W = IDX_W + 1;

    occ_e             st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Output process: decode of the state register
    always_comb begin
        full      = (st_q == OCC_FULL);
        empty     = (st_q == OCC_EMPTY);
        alloc_ok  = alloc_req && !full && !flush;
        commit_ok = head_done && !empty && !flush;
    end

    // Next-state logic
    always_comb begin
        cnt_d = cnt_q;
        if (alloc_ok && !commit_ok) begin
            cnt_d = cnt_q + 1'b1;
        end else if (commit_ok && !alloc_ok) begin
            cnt_d = cnt_q - 1'b1;
        end

        st_d = st_q;
        unique case (st_q)
            OCC_EMPTY: begin
                if (alloc_ok) begin
                    st_d = OCC_PART;                          // T_FILL
                end
            end
            OCC_PART: begin
                if (alloc_ok && !commit_ok && cnt_q == CNT_W'(DEPTH - 1)) begin
                    st_d = OCC_FULL;                          // T_TOPUP
                end else if (commit_ok && !alloc_ok && cnt_q == CNT_W'(1)) begin
                    st_d = OCC_EMPTY;                         // T_DRAIN
                end
            end
            OCC_FULL: begin
                if (commit_ok) begin
                    st_d = OCC_PART;                          // T_RELEASE
                end
            end
            default: st_d = OCC_EMPTY;
        endcase
        if (flush) begin
            st_d  = OCC_EMPTY;                                // T_FLUSH
            cnt_d = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= OCC_EMPTY;
            cnt_q  <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (flush) begin
                head_q <= '0;
                tail_q <= '0;
            end else begin
                if (commit_ok) head_q <= bump(head_q);
                if (alloc_ok)  tail_q <= bump(tail_q);
            end
        end
    end

endmodule

// File: rtl/vrob_slots.sv
module vrob_slots #(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_ok,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [AREG_W-1:0] alloc_areg,
    input  logic              commit_ok,
    input  logic [IDX_W-1:0]  commit_idx,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              head_done,
    output logic [AREG_W-1:0] head_areg,
    output logic [DATA_W-1:0] head_data,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH-1:0]  live_vec;
    logic [DEPTH-1:0]  fin_vec;
    logic [AREG_W-1:0] areg_arr [DEPTH];
    logic [DATA_W-1:0] val_arr  [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic              live_q, fin_q;
        logic [AREG_W-1:0] areg_q;
        logic [DATA_W-1:0] val_q;
        logic              hit_a, hit_c, hit_w;

        assign hit_a = alloc_ok  && (alloc_idx  == IDX_W'(s));
        assign hit_c = commit_ok && (commit_idx == IDX_W'(s));
        assign hit_w = wb_en     && (wb_idx     == IDX_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q <= 1'b0;
                fin_q  <= 1'b0;
                areg_q <= '0;
                val_q  <= '0;
            end else if (flush) begin
                live_q <= 1'b0;
                fin_q  <= 1'b0;
            end else if (hit_a) begin
                live_q <= 1'b1;
                fin_q  <= 1'b0;
                areg_q <= alloc_areg;
            end else if (hit_c) begin
                live_q <= 1'b0;
                fin_q  <= 1'b0;
            end else if (hit_w && live_q) begin
                fin_q  <= 1'b1;
                val_q  <= wb_data;
            end
        end

        assign live_vec[s] = live_q;
        assign fin_vec[s]  = fin_q;
        assign areg_arr[s] = areg_q;
        assign val_arr[s]  = val_q;
    end

    always_comb begin
        head_done = live_vec[commit_idx] && fin_vec[commit_idx];
        head_areg = areg_arr[commit_idx];
        head_data = val_arr[commit_idx];
        rd_done   = live_vec[rd_idx] && fin_vec[rd_idx];
        rd_data   = val_arr[rd_idx];
    end

endmodule

// File: rtl/vrob_top.sv
module vrob_top #(
    parameter int DEPTH  = 16,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_req,
    input  logic [AREG_W-1:0] alloc_areg,
    output logic              alloc_ok,
    output logic [IDX_W-1:0]  alloc_tag,
    output logic              full,
    output logic              empty,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [IDX_W-1:0]  rd_tag,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              cm_en,
    output logic [AREG_W-1:0] cm_areg,
    output logic [DATA_W-1:0] cm_data
);

    logic             head_done;
    logic             commit_ok;
    logic [IDX_W-1:0] head_q;
    logic [IDX_W-1:0] tail_q;

    vrob_ctrl #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .alloc_req (alloc_req),
        .head_done (head_done),
        .alloc_ok  (alloc_ok),
        .commit_ok (commit_ok),
        .head_q    (head_q),
        .tail_q    (tail_q),
        .full      (full),
        .empty     (empty)
    );

    vrob_slots #(
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W),
        .AREG_W (AREG_W),
        .DATA_W (DATA_W)
    ) slots_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .alloc_ok   (alloc_ok),
        .alloc_idx  (tail_q),
        .alloc_areg (alloc_areg),
        .commit_ok  (commit_ok),
        .commit_idx (head_q),
        .wb_en      (wb_en),
        .wb_idx     (wb_tag),
        .wb_data    (wb_data),
        .rd_idx     (rd_tag),
        .head_done  (head_done),
        .head_areg  (cm_areg),
        .head_data  (cm_data),
        .rd_done    (rd_done),
        .rd_data    (rd_data)
    );

    assign alloc_tag = tail_q;
    assign cm_en     = commit_ok;

endmodule

// File: rtl/vrob_chk.sv
module vrob_chk #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             alloc_ok,
    input logic [IDX_W-1:0] alloc_tag,
    input logic             full,
    input logic             empty,
    input logic             cm_en
);

    // R3
    full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_ok);

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R5
    commit_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_en |-> !empty);

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !full));

    // R2
    tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ok && !flush) |=>
            (alloc_tag == (($past(alloc_tag) == IDX_W'(DEPTH - 1)) ? '0 : $past(alloc_tag) + 1'b1)));

    // R2
    tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ok && !flush) |=> $stable(alloc_tag));

    // R6
    commit_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && cm_en && !flush) |=> !full);

endmodule

bind vrob_top vrob_chk #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .alloc_ok  (alloc_ok),
    .alloc_tag (alloc_tag),
    .full      (full),
    .empty     (empty),
    .cm_en     (cm_en)
);

// File: tb/vrob_tb.sv
module vrob_top_tb_top;

    localparam int D  = 16;
    localparam int AW = 5;
    localparam int DW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          alloc_req = 1'b0;
    logic [AW-1:0] alloc_areg = '0;
    logic          alloc_ok;
    logic [IW-1:0] alloc_tag;
    logic          full, empty;
    logic          wb_en = 1'b0;
    logic [IW-1:0] wb_tag = '0;
    logic [DW-1:0] wb_data = '0;
    logic [IW-1:0] rd_tag = '0;
    logic          rd_done;
    logic [DW-1:0] rd_data;
    logic          cm_en;
    logic [AW-1:0] cm_areg;
    logic [DW-1:0] cm_data;

    always #5 clk = ~clk;

    vrob_top #(.DEPTH(D), .AREG_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_req(alloc_req), .alloc_areg(alloc_areg),
        .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
        .full(full), .empty(empty),
        .wb_en(wb_en), .wb_tag(wb_tag), .wb_data(wb_data),
        .rd_tag(rd_tag), .rd_done(rd_done), .rd_data(rd_data),
        .cm_en(cm_en), .cm_areg(cm_areg), .cm_data(cm_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    // Reference state built from the requirements
    bit            m_v [D];
    bit            m_d [D];
    logic [DW-1:0] m_val [D];
    logic [AW-1:0] m_ar [D];
    int            m_head = 0, m_tail = 0, m_cnt = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < D; k++) begin
            m_v[k] = 1'b0;
            m_d[k] = 1'b0;
            m_val[k] = '0;
            m_ar[k] = '0;
        end
        m_head = 0; m_tail = 0; m_cnt = 0;
    endtask

    // Drive inputs, then compare every output with the reference
    task automatic drive(input bit a, input int ar, input bit w, input int wt,
                         input logic [DW-1:0] wd, input int rt, input bit fl);
        bit exp_cm, exp_rd, exp_ok;
        alloc_req  = a;
        alloc_areg = AW'(ar);
        wb_en      = w;
        wb_tag     = IW'(wt);
        wb_data    = wd;
        rd_tag     = IW'(rt);
        flush      = fl;
        #4;
        exp_ok = a && (m_cnt < D) && !fl;
        exp_cm = !fl && (m_cnt > 0) && m_d[m_head];
        exp_rd = m_v[rt] && m_d[rt];
        chk("R3 full", 64'(full), 64'(m_cnt == D));
        chk("R9 empty", 64'(empty), 64'(m_cnt == 0));
        chk("R3 alloc_ok", 64'(alloc_ok), 64'(exp_ok));
        chk("R2/R10 alloc_tag", 64'(alloc_tag), 64'(m_tail));
        chk("R5 cm_en", 64'(cm_en), 64'(exp_cm));
        if (exp_cm) begin
            chk("R5 cm_areg", 64'(cm_areg), 64'(m_ar[m_head]));
            chk("R5 cm_data", 64'(cm_data), 64'(m_val[m_head]));
        end
        chk("R4 rd_done", 64'(rd_done), 64'(exp_rd));
        if (exp_rd) chk("R4 rd_data", 64'(rd_data), 64'(m_val[rt]));
    endtask

    // Clock edge, then reference update
    task automatic adv();
        bit c, ok;
        int wt;
        @(posedge clk);
        wt = int'(wb_tag);
        if (flush) begin
            for (int k = 0; k < D; k++) begin
                m_v[k] = 1'b0;
                m_d[k] = 1'b0;
            end
            m_head = 0; m_tail = 0; m_cnt = 0;
        end else begin
            c  = (m_cnt > 0) && m_d[m_head];
            ok = alloc_req && (m_cnt < D);
            if (c) begin
                m_v[m_head] = 1'b0;
                m_d[m_head] = 1'b0;
                m_head = (m_head + 1) % D;
                m_cnt--;
            end
            if (wb_en && m_v[wt]) begin
                m_d[wt] = 1'b1;
                m_val[wt] = wb_data;
            end
            if (ok) begin
                m_v[m_tail] = 1'b1;
                m_d[m_tail] = 1'b0;
                m_ar[m_tail] = alloc_areg;
                m_tail = (m_tail + 1) % D;
                m_cnt++;
            end
        end
        #1;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: state after reset
        drive(0, 0, 0, 0, '0, 0, 0);
        chk("R1 empty", 64'(empty), 64'd1);
        chk("R1 full", 64'(full), 64'd0);
        chk("R1 cm_en", 64'(cm_en), 64'd0);
        chk("R1 alloc_tag", 64'(alloc_tag), 64'd0);
        for (int k = 0; k < D; k++) begin
            rd_tag = IW'(k);
            #0.1;
            chk("R1 rd_done", 64'(rd_done), 64'd0);
        end
        adv();

        // R2, R3: fill every slot
        for (int i = 0; i < D; i++) begin
            drive(1, i + 3, 0, 0, '0, 0, 0);
            adv();
        end
        drive(1, 7, 0, 0, '0, 0, 0);
        chk("R3 blocked", 64'(alloc_ok), 64'd0);
        chk("R3 full", 64'(full), 64'd1);
        adv();

        // R4, R5: a younger slot finishes first
        drive(0, 0, 1, 3, 32'hA3, 3, 0);
        adv();
        drive(0, 0, 0, 0, '0, 3, 0);
        chk("R5 no early retire", 64'(cm_en), 64'd0);
        chk("R4 rd_done", 64'(rd_done), 64'd1);
        chk("R4 rd_data", 64'(rd_data), 64'hA3);
        adv();

        // R5, R6: the oldest finishes, retires, is freed
        drive(0, 0, 1, 0, 32'hB0, 0, 0);
        adv();
        drive(0, 0, 0, 0, '0, 0, 0);
        chk("R5 cm_en", 64'(cm_en), 64'd1);
        chk("R5 cm_areg", 64'(cm_areg), 64'd3);
        chk("R5 cm_data", 64'(cm_data), 64'hB0);
        adv();
        drive(1, 20, 0, 0, '0, 0, 0);
        chk("R6 freed", 64'(rd_done), 64'd0);
        chk("R6 not full", 64'(full), 64'd0);
        chk("R10 wrap tag", 64'(alloc_tag), 64'd0);
        adv();
        drive(0, 0, 0, 0, '0, 0, 0);
        chk("R10 reused unfinished", 64'(rd_done), 64'd0);
        adv();

        // Drain slots 1 and 2 (slot 3 is already done)
        drive(0, 0, 1, 1, 32'h11, 1, 0); adv();
        drive(0, 0, 1, 2, 32'h22, 2, 0); adv();
        for (int i = 0; i < 4; i++) begin
            drive(0, 0, 0, 0, '0, i, 0);
            adv();
        end

        // R9: allocate and retire together
        drive(0, 0, 1, 4, 32'h44, 4, 0); adv();
        drive(1, 9, 0, 0, '0, 4, 0);
        chk("R9 both", 64'(cm_en) + 64'(alloc_ok), 64'd2);
        adv();
        drive(0, 0, 0, 0, '0, 0, 0);
        chk("R9 occupancy", 64'(m_cnt), 64'd13);
        adv();

        // R8: flush with a competing allocation
        drive(1, 4, 0, 0, '0, 0, 1);
        chk("R8 no retire", 64'(cm_en), 64'd0);
        adv();
        drive(0, 0, 1, 5, 32'hDEAD, 5, 0);
        chk("R8 empty", 64'(empty), 64'd1);
        chk("R8 full", 64'(full), 64'd0);
        chk("R8 tag", 64'(alloc_tag), 64'd0);
        adv();

        // R7: writeback to a slot not held is ignored
        for (int i = 0; i < 6; i++) begin
            drive(1, i, 0, 0, '0, 5, 0);
            adv();
        end
        drive(0, 0, 0, 0, '0, 5, 0);
        chk("R7 ignored", 64'(rd_done), 64'd0);
        adv();

        // Sweep with different strides, flush midway
        for (int i = 0; i < 600; i++) begin
            drive((i % 4) != 3, i % 32, (i % 3) != 1, (i * 5 + 1) % D,
                  DW'(i) * 32'h01010101 ^ 32'hA5, (i * 3) % D, i == 300);
            adv();
        end

        finish_run();
    end

endmodule